// File: doc/BRIEF.md
# Complementary PWM Output Stage with Fault Brake

This block conditions a bank of raw PWM channel waveforms before they reach the pins. The channels are grouped in pairs (an even channel and the odd channel above it). A mode input chooses how each odd channel is derived. In independent mode it passes its own raw input. In complementary mode it is the inverse of its even partner. In synchronous mode it is a copy of its even partner. In complementary mode each pair can insert a programmable dead time that holds back every rising edge of both outputs. Pulses shorter than the dead time are removed.

After pairing and dead time, a per-channel inversion is applied. Two fault brakes then act on the result. Each brake takes one of two selectable sources. While a brake is active, the channels named in a brake mask are forced to the levels given in a level mask. A brake latches a flag that stays set until software clears it. Each flag can raise an interrupt. Last of all, a per-channel output enable drives disabled pins low. The block is fed by a PWM counter/comparator bank, and its outputs go straight to the pin drivers.

Top module: `pwm_out_stage`

## Requirements
- R1: In independent mode (mode 0), and with the reserved mode value 3, every output equals its raw input two clock edges after the raw input is sampled.
- R2: In complementary mode (mode 1) with dead time disabled, odd channel 2p+1 outputs the inverse of raw even channel 2p. The even channel passes through unchanged. The latency is two edges.
- R3: In synchronous mode (mode 2), odd channel 2p+1 outputs a copy of raw even channel 2p, with a latency of two edges.
- R4: In complementary mode, when dead time is enabled for a pair with length L, each rising edge of both outputs of that pair appears L clocks later than it would without dead time. Falling edges keep the two-edge latency.
- R5: With dead time L active, a high pulse on the conditioned signal that lasts L cycles or fewer never reaches the output. A pulse lasting L+1 cycles appears as a one-cycle pulse.
- R6: Brake 0 is sourced from ext_i[0] when brk_sel_i[0]=0, and from cmp_i[1] when brk_sel_i[0]=1. Brake 1 is sourced from ext_i[1] when brk_sel_i[1]=0, and from cmp_i[0] when brk_sel_i[1]=1. A brake whose brk_en_i bit is 0 ignores its sources. The source that is not selected has no effect.
- R7: While any brake is triggered or flagged, every channel whose brk_mask_i bit is 1 drives its brk_lvl_i bit, starting at the first edge after the source is sampled high. The other channels are unaffected.
- R8: A brake flag stays set after its source returns low, until a brk_clr_i pulse arrives while the source is low. A clear applied while the source is still active leaves the flag set. Outputs resume normal values one edge after the flag clears.
- R9: irq_o is high exactly when some brake flag is set and its brk_ie_i bit is 1.
- R10: When inv_i[i]=1, channel i's conditioned waveform is inverted. The inversion is not applied to a brake level.
- R11: A channel whose oen_i bit is 0 drives 0, whatever its inversion or brake level.
- R12: After reset, all outputs, both brake flags and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_i | input | NCH | Raw PWM waveforms, one per channel |
| mode_i | input | 2 | Pairing mode: 0 independent, 1 complementary, 2 synchronous, 3 as 0 |
| dz_en_i | input | NCH/2 | Dead time enable per pair |
| dz_len_i | input | NCH/2*DT_W | Dead time length per pair, in clocks (pair p in bits p*DT_W upward) |
| inv_i | input | NCH | Per-channel output inversion |
| oen_i | input | NCH | Per-channel output enable |
| ext_i | input | 2 | External fault inputs, active high |
| cmp_i | input | 2 | Comparator fault inputs, active high |
| brk_en_i | input | 2 | Brake enables |
| brk_sel_i | input | 2 | Brake source selects |
| brk_mask_i | input | NCH | Channels forced while braking |
| brk_lvl_i | input | NCH | Levels driven on forced channels |
| brk_clr_i | input | 2 | Brake flag clear pulses |
| brk_ie_i | input | 2 | Brake interrupt enables |
| pwm_o | output | NCH | Conditioned outputs |
| brk_flag_o | output | 2 | Latched brake flags |
| irq_o | output | 1 | Brake interrupt |

## Verification
Pairing is driven with raw patterns in which even and odd bits disagree. This separates a pass-through odd channel from an inverted one and from a copied one. Dead time is checked by counting edges until each output rises and falls, with pulses of exactly L and L+1 cycles. These show that only rising edges are delayed and that short pulses are dropped. The brake tests toggle selected and unselected sources and clear the flag both while the source is high and while it is low. The inversion and enable tests pick levels where the brake value and the inverted value differ, which shows the order in which the stages apply.

// File: rtl/pwmo_pkg.sv
package pwmo_pkg;
  localparam int NBRK = 2;

  typedef enum logic [1:0] {
    MODE_INDEP = 2'd0,
    MODE_COMPL = 2'd1,
    MODE_SYNC  = 2'd2,
    MODE_RSVD  = 2'd3
  } pair_mode_e;

  // derive the odd channel of a pair from the raw pair inputs
  function automatic logic odd_of_pair(input pair_mode_e m, input logic ev, input logic od);
    case (m)
      MODE_COMPL: return ~ev;
      MODE_SYNC:  return ev;
      default:    return od;
    endcase
  endfunction

  // brake b source: 0 -> own external input, 1 -> opposite comparator
  function automatic logic brake_source(input int b, input logic sel,
                                        input logic [NBRK-1:0] ext, input logic [NBRK-1:0] cmp);
    return sel ? cmp[NBRK-1-b] : ext[b];
  endfunction

  // final pin level for one channel
  function automatic logic pin_level(input logic wave, input logic inv, input logic brk,
                                     input logic lvl, input logic en);
    logic v;
    v = brk ? lvl : (wave ^ inv);
    return en & v;
  endfunction
endpackage

// File: rtl/pwmo_pair_map.sv
module pwmo_pair_map
  import pwmo_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic [1:0]     mode_i,
  input  logic [NCH-1:0] raw_i,
  output logic [NCH-1:0] map_o,
  output logic           compl_o
);
  localparam int NPAIR = NCH / 2;
  pair_mode_e mode;

  assign mode    = pair_mode_e'(mode_i);
  assign compl_o = (mode == MODE_COMPL);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign map_o[2*p]   = raw_i[2*p];
    assign map_o[2*p+1] = odd_of_pair(mode, raw_i[2*p], raw_i[2*p+1]);
  end

  initial begin
    if (NCH % 2 != 0) $error("NCH must be even");
  end
endmodule

// File: rtl/pwmo_deadband.sv
module pwmo_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_i,
  input  logic [DT_W-1:0] len_i,
  input  logic            in_i,
  output logic            q_o
);
  logic [DT_W-1:0] hi_cnt;
  logic            len_met;

  assign len_met = (hi_cnt >= len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      q_o    <= 1'b0;
    end else begin
      if (!in_i)        hi_cnt <= '0;
      else if (!len_met) hi_cnt <= hi_cnt + 1'b1;
      q_o <= act_i ? (in_i & len_met) : in_i;
    end
  end

  // a delayed rise requires the input to have been high at least two edges back
  AST_DT_RISE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(q_o) && $past(act_i) && ($past(len_i) != '0)) |-> $past(in_i, 2)) // R4
    else $error("dead time rise too early");
endmodule

// File: rtl/pwmo_brake.sv
module pwmo_brake
  import pwmo_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBRK-1:0] ext_i,
  input  logic [NBRK-1:0] cmp_i,
  input  logic [NBRK-1:0] en_i,
  input  logic [NBRK-1:0] sel_i,
  input  logic [NBRK-1:0] clr_i,
  output logic [NBRK-1:0] trig_o,
  output logic [NBRK-1:0] flag_o,
  output logic            hit_o
);
  for (genvar b = 0; b < NBRK; b++) begin : g_brk
    assign trig_o[b] = en_i[b] & brake_source(b, sel_i[b], ext_i, cmp_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o[b] <= 1'b0;
      else        flag_o[b] <= (flag_o[b] & ~clr_i[b]) | trig_o[b];
    end

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o[b] |=> flag_o[b]) // R6
      else $error("brake flag not set");
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[b] && !clr_i[b]) |=> flag_o[b]) // R8
      else $error("brake flag dropped without clear");
  end

  assign hit_o = |(flag_o | trig_o);
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwmo_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int DT_W = 8,
  localparam int NPAIR = NCH / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        raw_i,
  input  logic [1:0]            mode_i,
  input  logic [NPAIR-1:0]      dz_en_i,
  input  logic [NPAIR*DT_W-1:0] dz_len_i,
  input  logic [NCH-1:0]        inv_i,
  input  logic [NCH-1:0]        oen_i,
  input  logic [NBRK-1:0]       ext_i,
  input  logic [NBRK-1:0]       cmp_i,
  input  logic [NBRK-1:0]       brk_en_i,
  input  logic [NBRK-1:0]       brk_sel_i,
  input  logic [NCH-1:0]        brk_mask_i,
  input  logic [NCH-1:0]        brk_lvl_i,
  input  logic [NBRK-1:0]       brk_clr_i,
  input  logic [NBRK-1:0]       brk_ie_i,
  output logic [NCH-1:0]        pwm_o,
  output logic [NBRK-1:0]       brk_flag_o,
  output logic                  irq_o
);
  logic [NCH-1:0]  mapped;
  logic [NCH-1:0]  shaped;
  logic            is_compl;
  logic [NBRK-1:0] brk_trig;
  logic            brk_hit;

  pwmo_pair_map #(.NCH(NCH)) u_map (
    .mode_i (mode_i),
    .raw_i  (raw_i),
    .map_o  (mapped),
    .compl_o(is_compl)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwmo_deadband #(.DT_W(DT_W)) u_db (
      .clk  (clk),
      .rst_n(rst_n),
      .act_i(is_compl & dz_en_i[i/2]),
      .len_i(dz_len_i[(i/2)*DT_W +: DT_W]),
      .in_i (mapped[i]),
      .q_o  (shaped[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_o[i] <= 1'b0;
      else        pwm_o[i] <= pin_level(shaped[i], inv_i[i], brk_hit & brk_mask_i[i],
                                        brk_lvl_i[i], oen_i[i]);
    end

    AST_OEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !oen_i[i] |=> !pwm_o[i]) // R11
      else $error("disabled channel not low");
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pchk
    AST_COMPL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $past(is_compl) |-> !(shaped[2*p] && shaped[2*p+1])) // R2
      else $error("complementary pair both high");
  end

  pwmo_brake u_brk (
    .clk   (clk),
    .rst_n (rst_n),
    .ext_i (ext_i),
    .cmp_i (cmp_i),
    .en_i  (brk_en_i),
    .sel_i (brk_sel_i),
    .clr_i (brk_clr_i),
    .trig_o(brk_trig),
    .flag_o(brk_flag_o),
    .hit_o (brk_hit)
  );

  assign irq_o = |(brk_flag_o & brk_ie_i);

  AST_BRK_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    (|brk_trig) |=> ((pwm_o & brk_mask_i & ~brk_lvl_i) == '0 || $changed(brk_mask_i) || $changed(brk_lvl_i))) // R7
    else $error("braked channel not at safe level");
endmodule

// File: tb/pwm_out_stage_tb.sv
module pwm_out_stage_tb;
  localparam int  NCH = 6, DT_W = 8, NPAIR = NCH / 2;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] raw_i = '0, inv_i = '0, oen_i = '1, brk_mask_i = '0, brk_lvl_i = '0;
  logic [1:0] mode_i = 2'd0, ext_i = '0, cmp_i = '0, brk_en_i = '0, brk_sel_i = '0;
  logic [1:0] brk_clr_i = '0, brk_ie_i = '0;
  logic [NPAIR-1:0] dz_en_i = '0;
  logic [NPAIR*DT_W-1:0] dz_len_i = '0;
  logic [NCH-1:0] pwm_o;
  logic [1:0] brk_flag_o;
  logic irq_o;
  int nvec = 0, nerr = 0;

  always #(TCLK/2) clk = ~clk;

  pwm_out_stage #(.NCH(NCH), .DT_W(DT_W)) u_dut (.*);

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench-side view of the pairing rules
  function automatic logic [NCH-1:0] paired(int m, logic [NCH-1:0] r);
    logic [NCH-1:0] o;
    o = r;
    for (int p = 0; p < NPAIR; p++) begin
      if (m == 1) o[2*p+1] = !r[2*p];
      if (m == 2) o[2*p+1] = r[2*p];
    end
    return o;
  endfunction

  task automatic t_reset();
    check("R12 pwm", pwm_o, 0);
    check("R12 flag", brk_flag_o, 0);
    check("R12 irq", irq_o, 0);
  endtask

  task automatic t_indep();
    mode_i = 0; raw_i = 6'b101101; tick(2); check("R1 indep a", pwm_o, 6'b101101);
    raw_i = 6'b010010; tick(2); check("R1 indep b", pwm_o, 6'b010010);
    mode_i = 3; raw_i = 6'b110001; tick(2); check("R1 mode3", pwm_o, 6'b110001);
  endtask

  task automatic t_compl();
    mode_i = 1;
    raw_i = 6'b000001; tick(2); check("R2 compl a", pwm_o, paired(1, 6'b000001));
    check("R2 compl a lit", pwm_o, 6'b101001);
    raw_i = 6'b111110; tick(2); check("R2 compl b", pwm_o, paired(1, 6'b111110));
  endtask

  task automatic t_sync();
    mode_i = 2;
    raw_i = 6'b010001; tick(2); check("R3 sync a", pwm_o, 6'b110011);
    raw_i = 6'b101010; tick(2); check("R3 sync b", pwm_o, 6'b000000);
  endtask

  task automatic t_dead();
    int L = 3;
    mode_i = 1; dz_en_i = 3'b001; dz_len_i = '0; dz_len_i[DT_W-1:0] = 8'(L);
    raw_i = 6'b000000; tick(L + 4);
    check("R4 idle odd high", pwm_o[1:0], 2'b10);
    raw_i[0] = 1;
    tick(2); check("R4 odd falls fast", pwm_o[1], 0);
    check("R4 even held back", pwm_o[0], 0);
    tick(L - 1); check("R4 even still low at L+1", pwm_o[0], 0);
    tick(1); check("R4 even rises at L+2", pwm_o[0], 1);
    raw_i[0] = 0;
    tick(2); check("R4 even falls fast", pwm_o[0], 0);
    tick(L - 1); check("R4 odd still low", pwm_o[1], 0);
    tick(1); check("R4 odd rises", pwm_o[1], 1);
    // pulse of exactly L cycles on even channel
    begin
      logic seen = 0;
      raw_i[0] = 1; tick(L - 1);
      @(posedge clk); @(negedge clk); raw_i[0] = 0;
      for (int k = 0; k < L + 4; k++) begin tick(1); seen |= pwm_o[0]; end
      check("R5 short pulse dropped", seen, 0);
    end
    // pulse of L+1 cycles -> one cycle out
    begin
      int hc = 0;
      raw_i[0] = 1; tick(L);
      @(posedge clk); @(negedge clk); raw_i[0] = 0;
      for (int k = 0; k < L + 4; k++) begin tick(1); hc += pwm_o[0]; end
      check("R5 L+1 pulse width", hc, 1);
    end
    dz_en_i = '0;
  endtask

  task automatic t_brake();
    mode_i = 0; raw_i = 6'b001101; brk_mask_i = 6'b000011; brk_lvl_i = 6'b000010;
    brk_en_i = 2'b01; brk_sel_i = 2'b00; tick(2);
    check("R7 pre", pwm_o, 6'b001101);
    ext_i[0] = 1; tick(1);
    check("R7 forced", pwm_o, 6'b001110);
    check("R6 flag0 set", brk_flag_o, 2'b01);
    ext_i[0] = 0; tick(3);
    check("R8 latched pwm", pwm_o, 6'b001110);
    check("R8 latched flag", brk_flag_o, 2'b01);
    brk_ie_i = 2'b01; #1; check("R9 irq on", irq_o, 1);
    brk_ie_i = 2'b10; #1; check("R9 irq masked", irq_o, 0);
    ext_i[0] = 1; brk_clr_i = 2'b01; tick(1); brk_clr_i = 0;
    check("R8 clear while active", brk_flag_o, 2'b01);
    ext_i[0] = 0; tick(1);
    brk_clr_i = 2'b01; tick(1); brk_clr_i = 0;
    check("R8 cleared", brk_flag_o, 2'b00);
    tick(1); check("R8 resumed", pwm_o, 6'b001101);
    brk_sel_i = 2'b01; ext_i[0] = 1; tick(2);
    check("R6 unselected ext0 ignored", brk_flag_o, 0);
    check("R6 unselected no force", pwm_o, 6'b001101);
    ext_i[0] = 0; cmp_i[1] = 1; tick(1);
    check("R6 cmp1 on brake0", brk_flag_o, 2'b01);
    cmp_i[1] = 0; brk_clr_i = 2'b01; tick(1); brk_clr_i = 0;
    ext_i[1] = 1; tick(2);
    check("R6 brake1 disabled", brk_flag_o, 0);
    check("R6 disabled no force", pwm_o, 6'b001101);
    ext_i[1] = 0; brk_en_i = 2'b11; brk_sel_i = 2'b10; cmp_i[0] = 1; tick(1);
    check("R6 cmp0 on brake1", brk_flag_o, 2'b10);
    check("R7 brake1 forces", pwm_o, 6'b001110);
    cmp_i[0] = 0; brk_clr_i = 2'b10; tick(1); brk_clr_i = 0; tick(1);
    check("R8 brake1 cleared", brk_flag_o, 0);
    brk_en_i = 0; brk_ie_i = 0;
  endtask

  task automatic t_inv_oen();
    mode_i = 0; raw_i = 6'b000001; inv_i = 6'b000011; tick(2);
    check("R10 inverted", pwm_o, 6'b000010);
    brk_mask_i = 6'b000011; brk_lvl_i = 6'b000001; brk_en_i = 2'b01; brk_sel_i = 0;
    ext_i[0] = 1; tick(1);
    check("R10 brake level not inverted", pwm_o, 6'b000001);
    oen_i = 6'b111110; tick(1);
    check("R11 disabled over brake", pwm_o, 6'b000000);
    ext_i[0] = 0; brk_clr_i = 2'b01; tick(1); brk_clr_i = 0; brk_en_i = 0;
    raw_i = 6'b000000; oen_i = 6'b111100; tick(2);
    check("R11 disabled over inversion", pwm_o, 6'b000000);
    oen_i = '1; tick(2);
    check("R11 re-enabled", pwm_o, 6'b000011);
    inv_i = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk); @(negedge clk);
    t_reset();
    rst_n = 1; tick(1);
    t_reset();
    t_indep();
    t_compl();
    t_sync();
    t_dead();
    t_brake();
    t_inv_oen();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule